// File: doc/BRIEF.md
# Two-Word Debug Display Latch

This block is a register on a simple synchronous bus that drives two banks of hexadecimal digits, each bank holding one 16-bit word, for progress codes and debug values during bring-up. Software writes a 32-bit value to show it across both banks. Software can instead write a 16-bit word, and then the value already shown in the first bank moves to the second bank. The displays then hold the newest word and the one written before it.

A read of the register is a blanking command. It turns both banks dark and returns zero. It leaves the stored values in place. Each bank has its own enable. After a blank, one word write lights only the first bank, and a second word write lights both. Character generation for the digits is done outside this block.

Top module: `hex_debug_latch`

## Requirements
- R1: After reset both bank values are zero, both bank enables are low and the acknowledge is low.
- R2: A selected write with the long flag high puts wrData[31:16] in the second bank and wrData[15:0] in the first bank, and raises both enables.
- R3: A selected write with the long flag low copies the first bank's value into the second bank and loads wrData[15:0] into the first bank. wrData[31:16] has no effect.
- R4: On a word write the second bank's enable takes the first bank's previous enable and the first bank's enable goes high, so one word write after a blank lights only the first bank.
- R5: A selected read clears both enables and leaves both bank values unchanged.
- R6: rdData is zero at all times.
- R7: Every selected read or write is acknowledged by ack high for exactly the one cycle after the access cycle.
- R8: Read or write strobes with the select input low change no bank value or enable and produce no acknowledge.
- R9: When read and write strobes are both high in one selected cycle, the access acts as a read: both banks are blanked and no value is loaded.
- R10: Bank values and enables change only at the clock edge that ends an access cycle and are visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Address match for this register |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| isLong | input | 1 | Access size: 1 for 32-bit, 0 for 16-bit |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, always zero |
| ack | output | 1 | One-cycle acknowledge after an access |
| bankLo | output | 16 | First bank value (newest word) |
| bankHi | output | 16 | Second bank value (older word or upper half) |
| dispEnLo | output | 1 | First bank display enable |
| dispEnHi | output | 1 | Second bank display enable |

## Verification
The hardest state to reach is a mixed enable pattern: the first bank lit and the second dark while the second bank still holds an old nonzero value. That state only exists after a read followed by exactly one word write. The stimulus writes a long value, blanks it, and then issues one word write. The bench checks that the stale upper value has moved in from the first bank but stays dark. A second word write then shows that the enable moves across with the word. Simultaneous read and write strobes, and strobes without select, are applied between known states so that any unwanted load shows at the outputs.

// File: rtl/hex_debug_pkg.sv
package hex_debug_pkg;
  localparam int DIGIT_BITS = 4;
  localparam int NUM_BANKS  = 2;

  // Commands from control to datapath; at most one is active per cycle.
  typedef struct packed {
    logic loadLong;
    logic shiftWord;
    logic blank;
  } dispStrobe_t;
endpackage

// File: rtl/hex_debug_ctrl.sv
module hex_debug_ctrl
  import hex_debug_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sel,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic        isLong,
  output dispStrobe_t strobe,
  output logic        ack
);
  logic access;
  assign access = sel && (rdEn || wrEn);

  // Read has priority over write when both strobes are present.
  always_comb begin
    strobe = '0;
    if (sel) begin
      if (rdEn)        strobe.blank     = 1'b1;
      else if (wrEn) begin
        if (isLong)    strobe.loadLong  = 1'b1;
        else           strobe.shiftWord = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ack <= 1'b0;
    else       ack <= access;
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadLong, strobe.shiftWord, strobe.blank}));

  // R7
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sel && (rdEn || wrEn)) |=> ack);

  // R8
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sel && (rdEn || wrEn)) |=> !ack);
endmodule

// File: rtl/hex_debug_datapath.sv
module hex_debug_datapath
  import hex_debug_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int WORD_W = DIGITS * DIGIT_BITS,
  localparam int BUS_W  = NUM_BANKS * WORD_W
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  dispStrobe_t                      strobe,
  input  logic [BUS_W-1:0]                 wrData,
  output logic [NUM_BANKS-1:0][WORD_W-1:0] bankVal,
  output logic [NUM_BANKS-1:0]             bankEn
);
  logic [NUM_BANKS-1:0][WORD_W-1:0] valNext;
  logic [NUM_BANKS-1:0]             enNext;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_comb begin
      valNext[b] = bankVal[b];
      enNext[b]  = bankEn[b];
      if (strobe.blank) begin
        enNext[b] = 1'b0;
      end else if (strobe.loadLong) begin
        valNext[b] = wrData[b*WORD_W +: WORD_W];
        enNext[b]  = 1'b1;
      end else if (strobe.shiftWord) begin
        if (b == 0) begin
          valNext[b] = wrData[WORD_W-1:0];
          enNext[b]  = 1'b1;
        end else begin
          valNext[b] = bankVal[(b > 0) ? b-1 : 0];
          enNext[b]  = bankEn[(b > 0) ? b-1 : 0];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankVal[b] <= '0;
        bankEn[b]  <= 1'b0;
      end else begin
        bankVal[b] <= valNext[b];
        bankEn[b]  <= enNext[b];
      end
    end
  end

  // R2
  long_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLong |=> (bankVal == $past(wrData)) && (&bankEn));

  // R3
  word_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftWord |=> (bankVal[1] == $past(bankVal[0]))
                      && (bankVal[0] == $past(wrData[WORD_W-1:0])));

  // R4
  word_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftWord |=> bankEn[0] && (bankEn[1] == $past(bankEn[0])));

  // R5
  blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.blank |=> (bankEn == '0) && $stable(bankVal));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.blank || strobe.loadLong || strobe.shiftWord)
      |=> $stable(bankVal) && $stable(bankEn));
endmodule

// File: rtl/hex_debug_latch.sv
module hex_debug_latch
  import hex_debug_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sel,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic        isLong,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        ack,
  output logic [15:0] bankLo,
  output logic [15:0] bankHi,
  output logic        dispEnLo,
  output logic        dispEnHi
);
  dispStrobe_t                strobe;
  logic [NUM_BANKS-1:0][15:0] bankVal;
  logic [NUM_BANKS-1:0]       bankEn;

  hex_debug_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sel    (sel),
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .isLong (isLong),
    .strobe (strobe),
    .ack    (ack)
  );

  hex_debug_datapath #(.DIGITS(4)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .bankVal (bankVal),
    .bankEn  (bankEn)
  );

  // Reads carry no information; R6
  assign rdData   = '0;
  assign bankLo   = bankVal[0];
  assign bankHi   = bankVal[1];
  assign dispEnLo = bankEn[0];
  assign dispEnHi = bankEn[1];
endmodule

// File: tb/sim_hex_debug_latch.sv
module sim_hex_debug_latch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        sel, rdEn, wrEn, isLong;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        ack;
  logic [15:0] bankLo, bankHi;
  logic        dispEnLo, dispEnHi;

  int checks = 0;
  int errors = 0;

  // Reference model, updated from the requirements
  logic [15:0] expLo = '0, expHi = '0;
  logic        expEnLo = 1'b0, expEnHi = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hex_debug_latch u0 (
    .clk(clk), .rstN(rstN), .sel(sel), .rdEn(rdEn), .wrEn(wrEn),
    .isLong(isLong), .wrData(wrData), .rdData(rdData), .ack(ack),
    .bankLo(bankLo), .bankHi(bankHi), .dispEnLo(dispEnLo), .dispEnHi(dispEnHi)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkState(input string req);
    check(req, {bankHi, bankLo, 14'd0, dispEnHi, dispEnLo},
               {expHi, expLo, 14'd0, expEnHi, expEnLo});
  endtask

  // Drive one cycle of access, then sample at the next falling edge.
  task automatic access(input logic s, input logic r, input logic w,
                        input logic lng, input logic [31:0] d, input logic expAck);
    @(negedge clk);
    sel = s; rdEn = r; wrEn = w; isLong = lng; wrData = d;
    check("R6 rdData", {32'd0, rdData}, 64'd0);
    @(negedge clk);
    sel = 0; rdEn = 0; wrEn = 0; isLong = 0; wrData = 32'hDEAD_BEEF;
    check("R7 ack", {63'd0, ack}, {63'd0, expAck});
  endtask

  task automatic idleAckLow();
    @(negedge clk);
    check("R7 ack single cycle", {63'd0, ack}, 64'd0);
  endtask

  task automatic testReset();
    checkState("R1 reset state");
    check("R1 ack", {63'd0, ack}, 64'd0);
  endtask

  task automatic testLong(input logic [31:0] d);
    access(1, 0, 1, 1, d, 1);
    expHi = d[31:16]; expLo = d[15:0]; expEnHi = 1; expEnLo = 1;
    checkState("R2 long write");
    idleAckLow();
  endtask

  task automatic testWord(input logic [31:0] d, input string req);
    access(1, 0, 1, 0, d, 1);
    expHi = expLo; expEnHi = expEnLo; expLo = d[15:0]; expEnLo = 1;
    checkState(req);
  endtask

  task automatic testRead();
    access(1, 1, 0, 0, 32'h0, 1);
    expEnHi = 0; expEnLo = 0;
    checkState("R5 read blanks, values kept");
    idleAckLow();
  endtask

  task automatic testUnselected();
    access(0, 0, 1, 1, 32'hABCD_1234, 0);
    checkState("R8 unselected long write ignored");
    access(0, 0, 1, 0, 32'h0000_7777, 0);
    checkState("R8 unselected word write ignored");
    access(0, 1, 0, 0, 32'h0, 0);
    checkState("R8 unselected read ignored");
  endtask

  task automatic testBoth();
    access(1, 1, 1, 1, 32'h5555_AAAA, 1);
    expEnHi = 0; expEnLo = 0;
    checkState("R9 read and write together acts as read");
  endtask

  task automatic testTiming();
    // R10: bank not yet updated in the access cycle itself
    @(negedge clk);
    sel = 1; wrEn = 1; isLong = 1; wrData = 32'h0F0F_F0F0;
    @(posedge clk); #1;
    check("R10 update after edge", {32'd0, bankHi, bankLo}, {32'd0, 32'h0F0F_F0F0});
    @(negedge clk);
    sel = 0; wrEn = 0; isLong = 0;
    expHi = 16'h0F0F; expLo = 16'hF0F0; expEnHi = 1; expEnLo = 1;
    checkState("R10 steady after write");
  endtask

  initial begin
    sel = 0; rdEn = 0; wrEn = 0; isLong = 0; wrData = '0;
    rstN = 0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    testLong(32'h1234_5678);
    testRead();
    testWord(32'hFFFF_00C3, "R4 one word after blank lights first bank only");
    testWord(32'h0000_BEEF, "R3 second word shifts history, upper data ignored");
    testWord(32'h8001_0042, "R3 third word shifts again");
    testUnselected();
    testBoth();
    testWord(32'h0000_1111, "R4 word after combined access");
    testLong(32'hCAFE_0001);
    testTiming();
    testWord(32'h0000_2222, "R3 word after long write");
    testRead();
    testRead();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule